// File: doc/BRIEF.md
# Combined Packet Classifier and QoS Scheduler

This block takes in two-word packets (a header word, then a payload word) on a valid/ready stream. It matches each header against a small content-addressable table and drops any packet whose header misses. A hit returns a traffic class and a one-bit priority. A flag bit in the header marks video traffic. A video packet has its header parked in a local header cache, and its payload is sent to an external processing element. The payload carries a tag that names the cache slot. When the processed payload comes back with that tag, the block puts the cached header back in front of it.

Ordinary packets, and rejoined video packets, then get an output port. The port is found by scanning a small port table one entry per cycle for the packet's class. High-priority packets go straight into the output FIFO. Low-priority packets wait in a hold queue until a QoS update pulse from the control plane releases them. Both tables are filled through simple write ports before traffic starts.

Top module: `classifier_sched`

## Requirements
- R1: After reset, `outValid` and `peValid` are 0 and `inReady` is 1.
- R2: The header compare against the key table takes one cycle. When several valid entries hold the same key, the lowest-numbered one supplies the class and priority. A header that matches no valid entry drops the whole packet, so nothing reaches the output or the processing-element port.
- R3: Header bit 16 set marks a video packet. Its payload is presented on `peData` with a tag on `peTag` and held until `peReady`. Nothing from that packet appears on the output before its payload returns.
- R4: A video header goes to the lowest free cache slot, and that slot number is the tag. A returned payload is joined to the header cached under `peRetTag`, in whatever order the returns arrive, and that slot is then freed.
- R5: `inReady` is 0 while every cache slot is occupied. It is also 0 in any cycle where a returned payload is offered between packets, because the return is served first.
- R6: The output port is taken from the first port-table entry, scanning from entry 0 upward, that is valid and holds the packet's class. If no entry qualifies, the packet is dropped.
- R7: A high-priority packet goes out as two words: the header with `outSop`=1, then the payload with `outEop`=1. `outPort` carries the port found in the table.
- R8: A low-priority packet is held until a `qosUpdate` pulse. High-priority packets that arrive later pass it.
- R9: A `qosUpdate` pulse releases every packet held at that moment, in arrival order. Packets held after the pulse wait for the next one.
- R10: While `outValid` is 1 and `outReady` is 0, the output word and its markers stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| camWe | input | 1 | Key-table write strobe |
| camAddr | input | 4 | Key-table entry index |
| camValid | input | 1 | Valid bit written |
| camKey | input | 32 | Header key written |
| camCls | input | 2 | Class written |
| camQos | input | 1 | Priority written (1 = high) |
| ramWe | input | 1 | Port-table write strobe |
| ramAddr | input | 2 | Port-table entry index |
| ramValid | input | 1 | Valid bit written |
| ramCls | input | 2 | Class the entry serves |
| ramPort | input | 2 | Output port of the entry |
| qosUpdate | input | 1 | Release pulse for held packets |
| inValid | input | 1 | Input word valid |
| inData | input | 32 | Input word (header, then payload) |
| inReady | output | 1 | Input word accepted |
| peValid | output | 1 | Payload to processing element valid |
| peData | output | 32 | Payload to processing element |
| peTag | output | 2 | Cache slot tag of that payload |
| peReady | input | 1 | Processing element accepts payload |
| peRetValid | input | 1 | Processed payload returned |
| peRetData | input | 32 | Processed payload |
| peRetTag | input | 2 | Tag of the returned payload |
| peRetReady | output | 1 | Return accepted |
| outValid | output | 1 | Output word valid |
| outData | output | 32 | Output word |
| outSop | output | 1 | First word of packet |
| outEop | output | 1 | Last word of packet |
| outPort | output | 2 | Destination port |
| outReady | input | 1 | Output consumer ready |

## Verification
Two functions can collide in the same cycle. A processed payload can come back from the processing element while a new header is waiting on the input. The bench provokes this by driving `peRetValid` and `inValid` on the same edge. It checks that `inReady` is low in that cycle, and that the rejoined video packet leaves before the ordinary packet. A second overlap comes from released held packets competing with a newly dispatched high-priority packet for the output FIFO. This is judged by comparing the output order with the order the bench expects.

// File: rtl/classifier_pkg.sv
package classifier_pkg;

  typedef enum logic [2:0] {
    ST_HDR, ST_PAY, ST_MATCH, ST_TOPE, ST_SCAN, ST_DISP
  } state_e;

  typedef struct packed {
    logic loadHdr;
    logic loadPay;
    logic latchMatch;
    logic cacheWr;
    logic takeRet;
    logic scanStart;
    logic scanStep;
    logic latchPort;
    logic pushOut;
    logic pushHold;
  } strobe_t;

  typedef struct packed {
    logic camHit;
    logic isVideo;
    logic qosHigh;
    logic cacheFull;
    logic scanHit;
    logic scanLast;
    logic outFull;
    logic holdFull;
  } status_t;

endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int WIDTH = 66,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN) push |-> !full); // R8
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN) pop |-> !empty); // R9
endmodule

// File: rtl/classifier_ctrl.sv
module classifier_ctrl
  import classifier_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    peReady,
  input  logic    peRetValid,
  input  status_t status,
  output strobe_t strobe,
  output logic    inReady,
  output logic    peValid,
  output logic    peRetReady
);
  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HDR;
    else       state <= nextState;
  end

  always_comb begin
    strobe     = '0;
    nextState  = state;
    inReady    = 1'b0;
    peValid    = 1'b0;
    peRetReady = 1'b0;
    case (state)
      ST_HDR: begin
        peRetReady = 1'b1;
        inReady    = !status.cacheFull && !peRetValid;
        if (peRetValid) begin
          strobe.takeRet   = 1'b1;
          strobe.scanStart = 1'b1;
          nextState        = ST_SCAN;
        end else if (inValid && inReady) begin
          strobe.loadHdr = 1'b1;
          nextState      = ST_PAY;
        end
      end
      ST_PAY: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.loadPay = 1'b1;
          nextState      = ST_MATCH;
        end
      end
      ST_MATCH: begin
        strobe.latchMatch = 1'b1;
        if (!status.camHit) nextState = ST_HDR;
        else if (status.isVideo) begin
          strobe.cacheWr = 1'b1;
          nextState      = ST_TOPE;
        end else begin
          strobe.scanStart = 1'b1;
          nextState        = ST_SCAN;
        end
      end
      ST_TOPE: begin
        peValid = 1'b1;
        if (peReady) nextState = ST_HDR;
      end
      ST_SCAN: begin
        if (status.scanHit) begin
          strobe.latchPort = 1'b1;
          nextState        = ST_DISP;
        end else if (status.scanLast) nextState = ST_HDR;
        else strobe.scanStep = 1'b1;
      end
      ST_DISP: begin
        if (status.qosHigh) begin
          if (!status.outFull) begin
            strobe.pushOut = 1'b1;
            nextState      = ST_HDR;
          end
        end else if (!status.holdFull) begin
          strobe.pushHold = 1'b1;
          nextState       = ST_HDR;
        end
      end
      default: nextState = ST_HDR;
    endcase
  end

  AST_PE_HELD: assert property (@(posedge clk) disable iff (!rstN) peValid && !peReady |=> peValid); // R3
  AST_MISS_NO_PE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MATCH) && !status.camHit |=> !peValid); // R2
endmodule

// File: rtl/classifier_dp.sv
module classifier_dp
  import classifier_pkg::*;
#(
  parameter int W           = 32,
  parameter int CAM_DEPTH   = 16,
  parameter int CLS_W       = 2,
  parameter int RAM_DEPTH   = 4,
  parameter int PORT_W      = 2,
  parameter int CACHE_DEPTH = 4,
  parameter int OUT_DEPTH   = 4,
  parameter int HOLD_DEPTH  = 4,
  parameter int VIDEO_BIT   = 16,
  localparam int CAM_AW = $clog2(CAM_DEPTH),
  localparam int RAM_AW = $clog2(RAM_DEPTH),
  localparam int TAG_W  = $clog2(CACHE_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  output status_t           status,
  input  logic              camWe,
  input  logic [CAM_AW-1:0] camAddr,
  input  logic              camValid,
  input  logic [W-1:0]      camKey,
  input  logic [CLS_W-1:0]  camCls,
  input  logic              camQos,
  input  logic              ramWe,
  input  logic [RAM_AW-1:0] ramAddr,
  input  logic              ramValid,
  input  logic [CLS_W-1:0]  ramCls,
  input  logic [PORT_W-1:0] ramPort,
  input  logic              qosUpdate,
  input  logic [W-1:0]      inData,
  output logic [W-1:0]      peData,
  output logic [TAG_W-1:0]  peTag,
  input  logic              peRetValid,
  input  logic [W-1:0]      peRetData,
  input  logic [TAG_W-1:0]  peRetTag,
  output logic              outValid,
  output logic [W-1:0]      outData,
  output logic              outSop,
  output logic              outEop,
  output logic [PORT_W-1:0] outPort,
  input  logic              outReady
);
  localparam int PKT_W = PORT_W + 2 * W;
  localparam int HCW   = $clog2(HOLD_DEPTH + 1);
  localparam int OCW   = $clog2(OUT_DEPTH + 1);

  logic [W-1:0] hdrReg, payReg;
  logic [CLS_W-1:0] clsReg;
  logic qosReg;
  logic [PORT_W-1:0] portReg;
  logic [RAM_AW-1:0] scanIdx;
  logic [TAG_W-1:0] curTag, allocIdx;

  // key table: one compare per entry, lowest index wins
  logic [CAM_DEPTH-1:0] camValidQ, camMatch;
  logic [W-1:0] camKeyQ [CAM_DEPTH];
  logic [CLS_W-1:0] camClsQ [CAM_DEPTH];
  logic [CAM_DEPTH-1:0] camQosQ;
  logic [CAM_AW-1:0] matchIdx;

  for (genvar g = 0; g < CAM_DEPTH; g++) begin : g_cam
    always_ff @(posedge clk) begin
      if (!rstN) camValidQ[g] <= 1'b0;
      else if (camWe && camAddr == CAM_AW'(g)) begin
        camValidQ[g] <= camValid;
        camKeyQ[g]   <= camKey;
        camClsQ[g]   <= camCls;
        camQosQ[g]   <= camQos;
      end
    end
    assign camMatch[g] = camValidQ[g] && (camKeyQ[g] == hdrReg);
  end

  always_comb begin
    matchIdx = '0;
    for (int i = CAM_DEPTH - 1; i >= 0; i--) if (camMatch[i]) matchIdx = CAM_AW'(i);
  end

  // port table
  logic [RAM_DEPTH-1:0] ramValidQ;
  logic [CLS_W-1:0] ramClsQ [RAM_DEPTH];
  logic [PORT_W-1:0] ramPortQ [RAM_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) ramValidQ <= '0;
    else if (ramWe) begin
      ramValidQ[ramAddr] <= ramValid;
      ramClsQ[ramAddr]   <= ramCls;
      ramPortQ[ramAddr]  <= ramPort;
    end
  end

  // header cache
  logic [CACHE_DEPTH-1:0] cacheValid;
  logic [W-1:0] cacheHdr [CACHE_DEPTH];
  logic [CLS_W-1:0] cacheCls [CACHE_DEPTH];
  logic [CACHE_DEPTH-1:0] cacheQos;

  always_comb begin
    allocIdx = '0;
    for (int i = CACHE_DEPTH - 1; i >= 0; i--) if (!cacheValid[i]) allocIdx = TAG_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cacheValid <= '0;
      curTag     <= '0;
      scanIdx    <= '0;
    end else begin
      if (strobe.cacheWr) begin
        cacheValid[allocIdx] <= 1'b1;
        cacheHdr[allocIdx]   <= hdrReg;
        cacheCls[allocIdx]   <= camClsQ[matchIdx];
        cacheQos[allocIdx]   <= camQosQ[matchIdx];
        curTag               <= allocIdx;
      end
      if (strobe.takeRet) cacheValid[peRetTag] <= 1'b0;
      if (strobe.scanStart) scanIdx <= '0;
      else if (strobe.scanStep) scanIdx <= scanIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.loadHdr) hdrReg <= inData;
    if (strobe.loadPay) payReg <= inData;
    if (strobe.latchMatch) begin
      clsReg <= camClsQ[matchIdx];
      qosReg <= camQosQ[matchIdx];
    end
    if (strobe.takeRet) begin
      hdrReg <= cacheHdr[peRetTag];
      payReg <= peRetData;
      clsReg <= cacheCls[peRetTag];
      qosReg <= cacheQos[peRetTag];
    end
    if (strobe.latchPort) portReg <= ramPortQ[scanIdx];
  end

  // hold queue, release counter and output FIFO
  logic [PKT_W-1:0] holdDout, outDout, outDin;
  logic holdEmpty, holdFull, outEmpty, outFull, moveHold, outPop, wordSel;
  logic [HCW-1:0] holdCount, releaseCnt;
  logic [OCW-1:0] outCount;

  assign moveHold = (releaseCnt != '0) && !holdEmpty && !outFull && !strobe.pushOut;
  assign outDin   = moveHold ? holdDout : {portReg, hdrReg, payReg};

  pkt_fifo #(.WIDTH(PKT_W), .DEPTH(HOLD_DEPTH)) i_hold (
    .clk, .rstN, .push(strobe.pushHold), .din({portReg, hdrReg, payReg}), .pop(moveHold),
    .dout(holdDout), .empty(holdEmpty), .full(holdFull), .count(holdCount));

  pkt_fifo #(.WIDTH(PKT_W), .DEPTH(OUT_DEPTH)) i_out (
    .clk, .rstN, .push(strobe.pushOut || moveHold), .din(outDin), .pop(outPop),
    .dout(outDout), .empty(outEmpty), .full(outFull), .count(outCount));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      releaseCnt <= '0;
      wordSel    <= 1'b0;
    end else begin
      if (qosUpdate) releaseCnt <= holdCount - HCW'(moveHold);
      else if (moveHold) releaseCnt <= releaseCnt - 1'b1;
      if (outValid && outReady) wordSel <= !wordSel;
    end
  end

  assign outValid = !outEmpty;
  assign outPop   = outValid && outReady && wordSel;
  assign outPort  = outDout[PKT_W-1 -: PORT_W];
  assign outData  = wordSel ? outDout[W-1:0] : outDout[2*W-1:W];
  assign outSop   = !wordSel;
  assign outEop   = wordSel;
  assign peData   = payReg;
  assign peTag    = curTag;

  assign status.camHit    = |camMatch;
  assign status.isVideo   = hdrReg[VIDEO_BIT];
  assign status.qosHigh   = qosReg;
  assign status.cacheFull = &cacheValid;
  assign status.scanHit   = ramValidQ[scanIdx] && (ramClsQ[scanIdx] == clsReg);
  assign status.scanLast  = (scanIdx == RAM_AW'(RAM_DEPTH - 1));
  assign status.outFull   = outFull;
  assign status.holdFull  = holdFull;

  AST_CACHE_WR_FREE: assert property (@(posedge clk) disable iff (!rstN) strobe.cacheWr |-> !(&cacheValid)); // R5
  AST_RET_SLOT_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeRet && peRetValid |-> cacheValid[peRetTag]); // R4
  AST_RELEASE_BOUND: assert property (@(posedge clk) disable iff (!rstN) releaseCnt <= holdCount); // R9
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outSop) && $stable(outPort)); // R10
endmodule

// File: rtl/classifier_sched.sv
module classifier_sched
  import classifier_pkg::*;
#(
  parameter int W           = 32,
  parameter int CAM_DEPTH   = 16,
  parameter int CLS_W       = 2,
  parameter int RAM_DEPTH   = 4,
  parameter int PORT_W      = 2,
  parameter int CACHE_DEPTH = 4,
  parameter int OUT_DEPTH   = 4,
  parameter int HOLD_DEPTH  = 4,
  parameter int VIDEO_BIT   = 16,
  localparam int CAM_AW = $clog2(CAM_DEPTH),
  localparam int RAM_AW = $clog2(RAM_DEPTH),
  localparam int TAG_W  = $clog2(CACHE_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              camWe,
  input  logic [CAM_AW-1:0] camAddr,
  input  logic              camValid,
  input  logic [W-1:0]      camKey,
  input  logic [CLS_W-1:0]  camCls,
  input  logic              camQos,
  input  logic              ramWe,
  input  logic [RAM_AW-1:0] ramAddr,
  input  logic              ramValid,
  input  logic [CLS_W-1:0]  ramCls,
  input  logic [PORT_W-1:0] ramPort,
  input  logic              qosUpdate,
  input  logic              inValid,
  input  logic [W-1:0]      inData,
  output logic              inReady,
  output logic              peValid,
  output logic [W-1:0]      peData,
  output logic [TAG_W-1:0]  peTag,
  input  logic              peReady,
  input  logic              peRetValid,
  input  logic [W-1:0]      peRetData,
  input  logic [TAG_W-1:0]  peRetTag,
  output logic              peRetReady,
  output logic              outValid,
  output logic [W-1:0]      outData,
  output logic              outSop,
  output logic              outEop,
  output logic [PORT_W-1:0] outPort,
  input  logic              outReady
);
  strobe_t strobe;
  status_t status;

  classifier_ctrl i_ctrl (
    .clk, .rstN, .inValid, .peReady, .peRetValid, .status, .strobe,
    .inReady, .peValid, .peRetReady);

  classifier_dp #(
    .W(W), .CAM_DEPTH(CAM_DEPTH), .CLS_W(CLS_W), .RAM_DEPTH(RAM_DEPTH), .PORT_W(PORT_W),
    .CACHE_DEPTH(CACHE_DEPTH), .OUT_DEPTH(OUT_DEPTH), .HOLD_DEPTH(HOLD_DEPTH), .VIDEO_BIT(VIDEO_BIT)
  ) i_dp (
    .clk, .rstN, .strobe, .status, .camWe, .camAddr, .camValid, .camKey, .camCls, .camQos,
    .ramWe, .ramAddr, .ramValid, .ramCls, .ramPort, .qosUpdate, .inData, .peData, .peTag,
    .peRetValid, .peRetData, .peRetTag, .outValid, .outData, .outSop, .outEop, .outPort, .outReady);
endmodule

// File: tb/test_classifier_sched.sv
module test_classifier_sched;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, camWe, camValid, camQos, ramWe, ramValid, qosUpdate, inValid, inReady;
  logic [3:0] camAddr;
  logic [31:0] camKey, inData, peData, peRetData, outData;
  logic [1:0] camCls, ramAddr, ramCls, ramPort, peTag, peRetTag, outPort;
  logic peValid, peReady, peRetValid, peRetReady, outValid, outSop, outEop, outReady;

  classifier_sched i_classifier_sched (.*);

  localparam logic [31:0] MASK = 32'hA5A5_0000;
  localparam logic [31:0] K_PLAIN = 32'h1000_0000, K_VID = 32'h1001_0000, K_LOW = 32'h2000_0000,
    K_LOWV = 32'h2001_0000, K_DUP = 32'h3000_0000, K_NOPORT = 32'h4000_0000, K_OFF = 32'h5000_0000;

  typedef struct packed { logic [31:0] h; logic [31:0] p; logic [1:0] port; } pkt_s;
  typedef struct packed { logic [1:0] tag; logic [31:0] d; } pe_s;
  pkt_s gotQ[$], expQ[$];
  pe_s peQ[$];
  logic [31:0] curH;
  logic [1:0] curPort;

  int checks = 0, errors = 0;
  logic [31:0] bKey [16];
  logic [1:0] bCls [16];
  logic bQos [16], bVal [16];
  logic [1:0] bRCls [4], bRPort [4];
  logic bRVal [4];

  task automatic chk(input bit ok, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", what);
    end
  endtask

  function automatic bit calc(input logic [31:0] h, output logic [1:0] port, output bit hi);
    int c = -1;
    port = 2'd0;
    hi = 1'b0;
    for (int i = 0; i < 16; i++) if (c < 0 && bVal[i] && bKey[i] == h) c = i;
    if (c < 0) return 1'b0;
    hi = bQos[c];
    for (int j = 0; j < 4; j++) if (bRVal[j] && bRCls[j] == bCls[c]) begin
      port = bRPort[j];
      return 1'b1;
    end
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (outValid && outReady) begin
      chk(outSop != outEop, $sformatf("R7 marker sop=%b eop=%b exp exactly one", outSop, outEop));
      if (outSop) begin
        curH = outData;
        curPort = outPort;
      end else gotQ.push_back('{curH, outData, curPort});
    end
    if (peValid && peReady) peQ.push_back('{peTag, peData});
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic camWrite(input int i, input bit v, input logic [31:0] k, input logic [1:0] c, input bit q);
    bVal[i] = v; bKey[i] = k; bCls[i] = c; bQos[i] = q;
    camWe = 1; camAddr = 4'(i); camValid = v; camKey = k; camCls = c; camQos = q;
    tick();
    camWe = 0;
  endtask

  task automatic ramWrite(input int i, input bit v, input logic [1:0] c, input logic [1:0] p);
    bRVal[i] = v; bRCls[i] = c; bRPort[i] = p;
    ramWe = 1; ramAddr = 2'(i); ramValid = v; ramCls = c; ramPort = p;
    tick();
    ramWe = 0;
  endtask

  task automatic sendPkt(input logic [31:0] h, input logic [31:0] p);
    inValid = 1; inData = h;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    tick();
    inData = p;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    tick();
    inValid = 0;
  endtask

  task automatic peReturn(input logic [1:0] t, input logic [31:0] d);
    peRetValid = 1; peRetTag = t; peRetData = d;
    @(negedge clk);
    while (!peRetReady) @(negedge clk);
    tick();
    peRetValid = 0;
  endtask

  task automatic waitPe(output pe_s e, input string req);
    int n = 0;
    while (peQ.size() == 0 && n < 200) begin tick(); n++; end
    chk(peQ.size() != 0, $sformatf("%s no payload at PE port (got 0 exp 1)", req));
    e = (peQ.size() != 0) ? peQ.pop_front() : '0;
  endtask

  task automatic expectPkt(input logic [31:0] h, input logic [31:0] p, input logic [1:0] port, input string req);
    int n = 0;
    pkt_s g;
    while (gotQ.size() == 0 && n < 300) begin tick(); n++; end
    if (gotQ.size() == 0) begin
      chk(0, $sformatf("%s no packet got none exp %h/%h", req, h, p));
      return;
    end
    g = gotQ.pop_front();
    chk(g.h == h && g.p == p && g.port == port,
      $sformatf("%s got %h/%h port %0d exp %h/%h port %0d", req, g.h, g.p, g.port, h, p, port));
  endtask

  task automatic expectNone(input int cyc, input string req);
    repeat (cyc) tick();
    chk(gotQ.size() == 0, $sformatf("%s got %0d packets exp 0", req, gotQ.size()));
  endtask

  task automatic pulseQos();
    tick();
    qosUpdate = 1;
    tick();
    qosUpdate = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired got hang exp finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    pe_s e, e0, e1, e2, e3;
    logic [31:0] d0;
    logic [1:0] port;
    bit hi, ok;
    void'($urandom(32'd11));
    for (int i = 0; i < 16; i++) begin bVal[i] = 0; bKey[i] = '0; bCls[i] = '0; bQos[i] = 0; end
    for (int j = 0; j < 4; j++) begin bRVal[j] = 0; bRCls[j] = '0; bRPort[j] = '0; end
    rstN = 0; camWe = 0; camAddr = '0; camValid = 0; camKey = '0; camCls = '0; camQos = 0;
    ramWe = 0; ramAddr = '0; ramValid = 0; ramCls = '0; ramPort = '0; qosUpdate = 0;
    inValid = 0; inData = '0; peReady = 1; peRetValid = 0; peRetData = '0; peRetTag = '0; outReady = 1;
    repeat (4) tick();
    rstN = 1;
    @(negedge clk);
    chk(!outValid && !peValid && inReady, $sformatf("R1 reset got out=%b pe=%b rdy=%b exp 0 0 1", outValid, peValid, inReady));

    camWrite(0, 1, K_PLAIN, 2'd0, 1);
    camWrite(1, 1, K_VID, 2'd1, 1);
    camWrite(2, 1, K_LOW, 2'd2, 0);
    camWrite(3, 1, K_LOWV, 2'd2, 0);
    camWrite(4, 1, K_DUP, 2'd1, 1);
    camWrite(5, 1, K_DUP, 2'd2, 1);
    camWrite(6, 1, K_NOPORT, 2'd3, 1);
    camWrite(7, 0, K_OFF, 2'd0, 1);
    ramWrite(0, 1, 2'd2, 2'd3);
    ramWrite(1, 0, 2'd0, 2'd1);
    ramWrite(2, 1, 2'd0, 2'd2);
    ramWrite(3, 1, 2'd1, 2'd1);

    // R7 plain high packet, port from first valid entry for class 0 (R6)
    sendPkt(K_PLAIN, 32'h0000_00A0);
    expectPkt(K_PLAIN, 32'h0000_00A0, 2'd2, "R7/R6 plain");
    // R2 lowest matching entry wins
    sendPkt(K_DUP, 32'h0000_00A1);
    expectPkt(K_DUP, 32'h0000_00A1, 2'd1, "R2 lowest entry");
    // R2 miss via invalid entry and unknown video key
    sendPkt(K_OFF, 32'h0000_00A2);
    sendPkt(32'h5001_0000, 32'h0000_00A3);
    expectNone(40, "R2 miss drop");
    chk(peQ.size() == 0, $sformatf("R2 miss PE traffic got %0d exp 0", peQ.size()));
    // R6 no port for class
    sendPkt(K_NOPORT, 32'h0000_00A4);
    expectNone(40, "R6 scan miss drop");

    // R3 video split and R4 rejoin
    sendPkt(K_VID, 32'h0000_0B00);
    waitPe(e, "R3");
    chk(e.d == 32'h0000_0B00 && e.tag == 2'd0, $sformatf("R3 pe got %h tag %0d exp 00000b00 tag 0", e.d, e.tag));
    expectNone(20, "R3 nothing before return");
    tick();
    peReturn(e.tag, e.d ^ MASK);
    expectPkt(K_VID, 32'h0000_0B00 ^ MASK, 2'd1, "R4 rejoin");

    // R10 output backpressure
    outReady = 0;
    sendPkt(K_PLAIN, 32'h0000_0C00);
    begin
      int n = 0;
      while (!outValid && n < 100) begin tick(); n++; end
    end
    @(negedge clk);
    d0 = outData;
    repeat (5) tick();
    @(negedge clk);
    chk(outValid && outSop && outData == d0, $sformatf("R10 stall got %h v=%b exp %h", outData, outValid, d0));
    tick();
    outReady = 1;
    expectPkt(K_PLAIN, 32'h0000_0C00, 2'd2, "R10 after stall");

    // R5 and R4: fill cache, out-of-order returns
    sendPkt(K_VID, 32'h100); waitPe(e0, "R4");
    sendPkt(K_VID, 32'h101); waitPe(e1, "R4");
    sendPkt(K_VID, 32'h102); waitPe(e2, "R4");
    sendPkt(K_VID, 32'h103); waitPe(e3, "R4");
    chk(e0.tag == 0 && e1.tag == 1 && e2.tag == 2 && e3.tag == 3,
      $sformatf("R4 tags got %0d%0d%0d%0d exp 0123", e0.tag, e1.tag, e2.tag, e3.tag));
    tick();
    inValid = 1; inData = K_PLAIN;
    repeat (4) begin
      @(negedge clk);
      chk(!inReady, $sformatf("R5 full got rdy=%b exp 0", inReady));
    end
    tick();
    inValid = 0;
    peReturn(2'd2, 32'h102 ^ MASK);
    expectPkt(K_VID, 32'h102 ^ MASK, 2'd1, "R4 out of order tag 2");
    peReturn(2'd0, 32'h100 ^ MASK);
    expectPkt(K_VID, 32'h100 ^ MASK, 2'd1, "R4 out of order tag 0");
    @(negedge clk);
    chk(inReady, $sformatf("R5 slot freed got rdy=%b exp 1", inReady));
    tick();
    peReturn(2'd3, 32'h103 ^ MASK);
    peReturn(2'd1, 32'h101 ^ MASK);
    expectPkt(K_VID, 32'h103 ^ MASK, 2'd1, "R4 tag 3");
    expectPkt(K_VID, 32'h101 ^ MASK, 2'd1, "R4 tag 1");

    // R5 same-cycle return and new header: return wins
    sendPkt(K_VID, 32'h0000_0D00);
    waitPe(e, "R5");
    tick();
    fork
      peReturn(e.tag, 32'h0000_0D00 ^ MASK);
      begin
        inValid = 1; inData = K_PLAIN;
        @(negedge clk);
        chk(!inReady, $sformatf("R5 collision got rdy=%b exp 0", inReady));
        while (!inReady) @(negedge clk);
        tick();
        inData = 32'h0000_0D01;
        @(negedge clk);
        while (!inReady) @(negedge clk);
        tick();
        inValid = 0;
      end
    join
    expectPkt(K_VID, 32'h0000_0D00 ^ MASK, 2'd1, "R5 return first");
    expectPkt(K_PLAIN, 32'h0000_0D01, 2'd2, "R5 input second");

    // R8 low held, later high passes
    sendPkt(K_LOW, 32'h0000_0E00);
    expectNone(30, "R8 low held");
    sendPkt(K_PLAIN, 32'h0000_0E01);
    expectPkt(K_PLAIN, 32'h0000_0E01, 2'd2, "R8 high passes");
    pulseQos();
    expectPkt(K_LOW, 32'h0000_0E00, 2'd3, "R9 release");

    // R9 order of release, including a low video packet
    sendPkt(K_LOW, 32'h0000_0F00);
    sendPkt(K_LOWV, 32'h0000_0F01);
    waitPe(e, "R3 low video");
    tick();
    peReturn(e.tag, 32'h0000_0F01 ^ MASK);
    expectNone(30, "R8 two held");
    pulseQos();
    expectPkt(K_LOW, 32'h0000_0F00, 2'd3, "R9 first");
    expectPkt(K_LOWV, 32'h0000_0F01 ^ MASK, 2'd3, "R9 second");
    sendPkt(K_LOW, 32'h0000_0F02);
    expectNone(40, "R9 later packet waits for next pulse");
    pulseQos();
    expectPkt(K_LOW, 32'h0000_0F02, 2'd3, "R9 next pulse");

    // random mix of high-priority hits and misses
    for (int k = 0; k < 40; k++) begin
      logic [31:0] h, p;
      int sel = $urandom % 5;
      p = $urandom;
      case (sel)
        0: h = K_PLAIN;
        1: h = K_VID;
        2: h = K_DUP;
        3: h = K_OFF;
        default: h = {4'h7, 28'($urandom)};
      endcase
      ok = calc(h, port, hi);
      sendPkt(h, p);
      if (ok && h[16]) begin
        waitPe(e, "R3 random");
        chk(e.tag == 2'd0 && e.d == p, $sformatf("R4 random tag got %0d/%h exp 0/%h", e.tag, e.d, p));
        tick();
        peReturn(e.tag, e.d ^ MASK);
        expQ.push_back('{h, p ^ MASK, port});
      end else if (ok && hi) expQ.push_back('{h, p, port});
    end
    repeat (60) tick();
    chk(gotQ.size() == expQ.size(), $sformatf("R2 random count got %0d exp %0d", gotQ.size(), expQ.size()));
    while (expQ.size() != 0 && gotQ.size() != 0) begin
      pkt_s x = expQ.pop_front();
      pkt_s g = gotQ.pop_front();
      chk(g == x, $sformatf("R7 random got %h/%h/%0d exp %h/%h/%0d", g.h, g.p, g.port, x.h, x.p, x.port));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule